// File: doc/BRIEF.md
# Local Scan Port Park/Unpark Sequencer

This block controls the test mode select line of one local scan chain that hangs off a scan bridge. While the port is parked, the block holds the local TMS at a fixed level. High holds the local TAP in Test-Logic-Reset. Low holds it in Run-Test/Idle, Pause-DR or Pause-IR. While the port is active, the local TMS repeats the backplane TMS, so the local TAP moves in step with the bridge TAP.

An unpark request does not take effect at once. The block first drives the local TMS low, so a chain held in reset settles in Run-Test/Idle. It then waits until the bridge TAP is in the synchronization state that matches where the chain was parked. Only in that state does it switch the local TMS over to the backplane TMS.

The block also provides the three reset levels for its port:
- an asynchronous test reset or a bridge Test-Logic-Reset parks the port in Test-Logic-Reset;
- a soft-reset strobe forces the local TMS high;
- a park request for Test-Logic-Reset resets this port alone.

All local TMS changes are launched on the falling edge of the backplane TCK.

Top module: `lsp_park_ctrl`

## Requirements
- R1: While `trst_n` is low, `local_tms` is 1 and `port_active` is 0, and the port is parked in Test-Logic-Reset.
- R2: When `bridge_state` equals the Test-Logic-Reset code 4'hF at a rising TCK edge, the port becomes parked in Test-Logic-Reset: `port_active` is 0 after that edge and `local_tms` is 1 from the next falling edge.
- R3: A `park_req` pulse takes its target from `park_tgt`: 0 for Test-Logic-Reset, 1 for Run-Test/Idle, 2 for Pause-DR, 3 for Pause-IR. It is accepted while the port is active or parked in Test-Logic-Reset. After the accepting rising edge, `port_active` is 0. From the next falling edge, `local_tms` is 1 for target 0 and 0 for the other targets.
- R4: An `unpark_req` pulse while the port is parked makes `local_tms` 0 from the next falling edge, and `port_active` stays 0 until synchronization.
- R5: A port parked in Test-Logic-Reset or Run-Test/Idle becomes active only when `bridge_state` is Run-Test/Idle (4'hC). The codes 4'h3 and 4'hB leave it waiting.
- R6: A port parked in Pause-DR becomes active only when `bridge_state` is Pause-DR (4'h3). The codes 4'hC and 4'hB leave it waiting.
- R7: A port parked in Pause-IR becomes active only when `bridge_state` is Pause-IR (4'hB). The codes 4'hC and 4'h3 leave it waiting.
- R8: Starting at the falling edge within the synchronization cycle, and at every falling edge while `port_active` is 1, `local_tms` takes the value of `bb_tms`. `port_active` rises at the rising edge that closes the synchronization cycle.
- R9: A `soft_rst_req` pulse parks the port in Test-Logic-Reset. `local_tms` is then 1 from the next falling edge, for at least five TCK cycles whatever `bb_tms` does.
- R10: A `park_req` with any target is ignored while the port is parked in Run-Test/Idle, Pause-DR or Pause-IR, or is waiting to synchronize. The port keeps its park state and its `local_tms` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Backplane test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| bridge_state | input | 4 | Current state code of the bridge TAP |
| bb_tms | input | 1 | Backplane test mode select |
| park_req | input | 1 | Park instruction strobe |
| park_tgt | input | 2 | Park target state for `park_req` |
| unpark_req | input | 1 | Unpark instruction strobe |
| soft_rst_req | input | 1 | Soft-reset instruction strobe |
| local_tms | output | 1 | Test mode select driven to the local chain |
| port_active | output | 1 | 1 while the port follows the backplane |

## Verification
The bench parks the port in each of the four states. In each case it presents the other two synchronization codes first and checks that the port stays parked with the local TMS low. A design that compared against the wrong synchronization state would unpark early and let the local chain drift off the bridge. It also checks that the local TMS follows the backplane in the synchronization cycle itself. A design that waited one more cycle would leave the local chain one state behind the bridge.

Re-parking in reset from the Run-Test/Idle park is issued and must leave the TMS low. A design that accepted it would drive the chain through an unsynchronized path. Soft reset and bridge reset are driven from the active state with the backplane TMS low. A design that kept following the backplane would never take the local TAP to reset.

// File: rtl/lsp_park_ctrl.sv
module lsp_park_ctrl #(
  parameter int STW = 4,
  parameter logic [STW-1:0] ST_TLR = 4'hF,
  parameter logic [STW-1:0] ST_RTI = 4'hC,
  parameter logic [STW-1:0] ST_PDR = 4'h3,
  parameter logic [STW-1:0] ST_PIR = 4'hB
) (
  input  logic           tck,
  input  logic           trst_n,
  input  logic [STW-1:0] bridge_state,
  input  logic           bb_tms,
  input  logic           park_req,
  input  logic [1:0]     park_tgt,
  input  logic           unpark_req,
  input  logic           soft_rst_req,
  output logic           local_tms,
  output logic           port_active
);

  localparam logic [1:0] P_TLR = 2'd0;
  localparam logic [1:0] P_RTI = 2'd1;
  localparam logic [1:0] P_PDR = 2'd2;
  localparam logic [1:0] P_PIR = 2'd3;

  logic [1:0] park_q;
  logic       pend_q, act_q, tms_q;
  logic       sync_hit, follow, parked_tlr, park_ok;

  always_comb begin
    case (park_q)
      P_TLR, P_RTI: sync_hit = (bridge_state == ST_RTI);
      P_PDR:        sync_hit = (bridge_state == ST_PDR);
      default:      sync_hit = (bridge_state == ST_PIR);
    endcase
  end

  assign follow     = act_q | (pend_q & sync_hit);
  assign parked_tlr = !act_q && !pend_q && (park_q == P_TLR);
  assign park_ok    = park_req && (act_q || parked_tlr);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      park_q <= P_TLR;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (bridge_state == ST_TLR || soft_rst_req) begin
      park_q <= P_TLR;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (park_ok) begin
      park_q <= park_tgt;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (unpark_req && !act_q && !pend_q) begin
      pend_q <= 1'b1;
    end else if (pend_q && sync_hit) begin
      pend_q <= 1'b0;
      act_q  <= 1'b1;
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)     tms_q <= 1'b1;
    else if (follow) tms_q <= bb_tms;
    else if (pend_q) tms_q <= 1'b0;
    else             tms_q <= parked_tlr;
  end

  assign local_tms   = tms_q;
  assign port_active = act_q;

endmodule

module lsp_park_ctrl_chk #(
  parameter int STW = 4,
  parameter logic [STW-1:0] ST_TLR = 4'hF,
  parameter logic [STW-1:0] ST_RTI = 4'hC,
  parameter logic [STW-1:0] ST_PDR = 4'h3,
  parameter logic [STW-1:0] ST_PIR = 4'hB
) (
  input logic           tck,
  input logic           trst_n,
  input logic [STW-1:0] bridge_state,
  input logic           soft_rst_req,
  input logic           local_tms,
  input logic           port_active,
  input logic           parked_tlr
);

  // R2
  bridge_tlr_park_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (bridge_state == ST_TLR) |=> (!port_active && parked_tlr));

  // R9
  soft_rst_park_chk: assert property (@(posedge tck) disable iff (!trst_n)
    soft_rst_req |=> parked_tlr);

  // R5
  sync_gate_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(port_active) |-> ($past(bridge_state) == ST_RTI ||
                            $past(bridge_state) == ST_PDR ||
                            $past(bridge_state) == ST_PIR));

  // R3
  tlr_tms_high_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (parked_tlr && $past(parked_tlr)) |-> local_tms);

endmodule

bind lsp_park_ctrl lsp_park_ctrl_chk #(
  .STW(STW), .ST_TLR(ST_TLR), .ST_RTI(ST_RTI), .ST_PDR(ST_PDR), .ST_PIR(ST_PIR)
) chk_i (
  .tck(tck), .trst_n(trst_n), .bridge_state(bridge_state),
  .soft_rst_req(soft_rst_req), .local_tms(local_tms),
  .port_active(port_active), .parked_tlr(parked_tlr)
);

// File: tb/lsp_park_ctrl_tb.sv
`timescale 1ns/1ps
module lsp_park_ctrl_tb_top;

  logic       tck = 1'b0;
  logic       trst_n;
  logic [3:0] bridge_state;
  logic       bb_tms, park_req, unpark_req, soft_rst_req;
  logic [1:0] park_tgt;
  logic       local_tms, port_active;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  localparam logic [3:0] IDLE_ST = 4'h7;

  always #2 tck = ~tck;

  lsp_park_ctrl dut_i (
    .tck(tck), .trst_n(trst_n), .bridge_state(bridge_state), .bb_tms(bb_tms),
    .park_req(park_req), .park_tgt(park_tgt), .unpark_req(unpark_req),
    .soft_rst_req(soft_rst_req), .local_tms(local_tms), .port_active(port_active)
  );

  task automatic chk(input string rq, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", rq, what, act, exp);
    end
  endtask

  task automatic step(); @(posedge tck); #1; endtask
  task automatic fall(); @(negedge tck); #1; endtask

  function automatic logic [3:0] sync_code(input logic [1:0] t);
    return (t < 2) ? 4'hC : (t == 2) ? 4'h3 : 4'hB;
  endfunction

  function automatic string sync_rq(input logic [1:0] t);
    return (t < 2) ? "R5" : (t == 2) ? "R6" : "R7";
  endfunction

  task automatic do_reset();
    trst_n = 1'b0; bridge_state = IDLE_ST; bb_tms = 1'b0;
    park_req = 0; park_tgt = 0; unpark_req = 0; soft_rst_req = 0;
    step(); step();
    chk("R1", "local_tms in reset", local_tms, 1'b1);
    chk("R1", "port_active in reset", port_active, 1'b0);
    trst_n = 1'b1;
    step();
  endtask

  task automatic do_park(input logic [1:0] t);
    park_req = 1'b1; park_tgt = t;
    step();
    park_req = 1'b0;
    chk("R3", "port_active after park", port_active, 1'b0);
    fall();
    chk("R3", "local_tms park level", local_tms, t == 2'd0);
    step();
  endtask

  task automatic unpark_sync(input logic [1:0] t);
    logic [3:0] codes [3] = '{4'hC, 4'h3, 4'hB};
    unpark_req = 1'b1;
    step();
    unpark_req = 1'b0;
    fall();
    chk("R4", "local_tms after unpark", local_tms, 1'b0);
    step();
    chk("R4", "still inactive while waiting", port_active, 1'b0);
    foreach (codes[i]) begin
      if (codes[i] != sync_code(t)) begin
        bridge_state = codes[i]; bb_tms = 1'b1;
        fall();
        chk(sync_rq(t), "local_tms at non-matching state", local_tms, 1'b0);
        step();
        chk(sync_rq(t), "no unpark at non-matching state", port_active, 1'b0);
      end
    end
    bridge_state = sync_code(t); bb_tms = 1'b1;
    fall();
    chk("R8", "local_tms follows in sync cycle", local_tms, 1'b1);
    step();
    chk(sync_rq(t), "active after sync state", port_active, 1'b1);
    bridge_state = IDLE_ST; bb_tms = 1'b0;
    fall();
    chk("R8", "local_tms follows bb_tms low", local_tms, 1'b0);
    step();
    bb_tms = 1'b1;
    fall();
    chk("R8", "local_tms follows bb_tms high", local_tms, 1'b1);
    step();
  endtask

  task automatic t_park_walk();
    for (int t = 0; t < 4; t++) begin
      do_reset();
      do_park(2'(t));
      unpark_sync(2'(t));
    end
  endtask

  task automatic t_repark_ignored();
    do_reset();
    do_park(2'd1);
    park_req = 1'b1; park_tgt = 2'd0;
    step();
    park_req = 1'b0;
    fall();
    chk("R10", "TLR park ignored from RTI park", local_tms, 1'b0);
    step();
    chk("R10", "still parked", port_active, 1'b0);
    unpark_req = 1'b1;
    step();
    unpark_req = 1'b0;
    park_req = 1'b1; park_tgt = 2'd0;
    step();
    park_req = 1'b0;
    fall();
    chk("R10", "park ignored while waiting", local_tms, 1'b0);
    bridge_state = 4'hC; bb_tms = 1'b1;
    step();
    chk("R10", "sync still honoured", port_active, 1'b1);
    bridge_state = IDLE_ST;
    step();
  endtask

  task automatic t_soft_reset();
    do_reset();
    unpark_sync(2'd0);
    bb_tms = 1'b0; soft_rst_req = 1'b1;
    step();
    soft_rst_req = 1'b0;
    chk("R9", "inactive after soft reset", port_active, 1'b0);
    for (int k = 0; k < 5; k++) begin
      fall();
      chk("R9", "local_tms held high", local_tms, 1'b1);
      step();
    end
  endtask

  task automatic t_bridge_tlr();
    do_reset();
    unpark_sync(2'd0);
    bb_tms = 1'b0; bridge_state = 4'hF;
    step();
    chk("R2", "inactive after bridge TLR", port_active, 1'b0);
    fall();
    chk("R2", "local_tms high after bridge TLR", local_tms, 1'b1);
    step();
    bridge_state = IDLE_ST;
    fall();
    chk("R2", "stays parked high", local_tms, 1'b1);
    step();
  endtask

  initial begin
    trst_n = 1'b0;
    t_park_walk();
    t_repark_ignored();
    t_soft_reset();
    t_bridge_tlr();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule